// File: doc/BRIEF.md
# Temperature limit event controller

This block sits between a temperature converter and a serial bus front end. It keeps the most recent 13-bit two's complement reading, with 0.0625°C per LSB. It holds three programmable trip points: high, low and critical. From these it derives three trip flags and one event state, and it drives a single pull-low enable for an open-drain alarm pin.

The bus front end writes and reads the registers through a word-wide port. Register addresses are 1 for configuration, 2 for the high limit, 3 for the low limit, 4 for the critical limit and 5 for the data word. Every other address reads zero.

The event can follow the trip flags directly (comparator mode). It can instead latch on each window crossing until software clears it (interrupt mode). It can also be limited to the critical trip only. Hysteresis, output polarity, an output enable, two set-only lock bits and a shutdown freeze are programmed through the configuration word.

Top module: `temp_evt_ctrl`

## Requirements
- R1: Reading address 5 returns the critical, high and low flags in bits 15, 14 and 13, and the stored temperature in bits 12..0. A strobed sample is loaded on the next clock edge unless configuration bit 8 (shutdown) is set, in which case the stored temperature does not change.
- R2: A write to a limit register (2 high, 3 low, 4 critical) keeps only bits 12..2. The other bits read back as zero. Bit 2 of a limit weighs 0.25°C, which is four temperature LSBs.
- R3: All trip flags are registered one cycle after the temperature or limit they depend on. The critical flag sets when temperature ≥ critical limit and clears when temperature < critical limit − hysteresis. The high flag sets when temperature > high limit and clears when temperature ≤ high limit − hysteresis. The low flag is set exactly while temperature < low limit.
- R4: Configuration bits 10..9 give the hysteresis in temperature LSBs: 00 → 0, 01 → 24, 10 → 48, 11 → 96.
- R5: With configuration bit 0 = 0 (comparator mode), the event state is registered one cycle after the flags. It equals the OR of all three flags, or only the critical flag when bit 2 is 1. The event state stays 0 while bit 3 (enable) is 0.
- R6: With bit 0 = 1 (interrupt mode) and bit 2 = 0, any change of the high or low flag sets a latch. The event is then the latch OR the critical flag. Writing configuration with bit 5 = 1 clears the latch, and bit 5 always reads 0.
- R7: A clear requested while the critical flag is set is held, and it clears the latch in the cycle after the critical flag drops.
- R8: Bits 7 and 6 (lock) can be set but never cleared, except by reset. While either is set, bits 0, 1, 3, 9 and 10 keep their values, and bit 8 can be cleared but not set. While bit 6 is set, bit 2 can be cleared but not set.
- R9: Writes to the critical limit are ignored while bit 7 is set. Writes to the high and low limits are ignored while bit 6 is set.
- R10: While bit 8 is set, the event state holds its value. Configuration bit 4 always reads the event state, independent of polarity.
- R11: The pin pull-low output equals the event state when bit 1 = 0 (active low), and its inverse when bit 1 = 1. A disabled output is therefore released for low polarity and pulled low for high polarity.
- R12: Reset clears every writable register and the temperature to zero, leaving the event state 0 and the pin released.
- R13: A limit write alone, with no new sample, can change the flags and raise the event two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_valid | input | 1 | Sample strobe from the converter |
| samp_data | input | 13 | Two's complement temperature sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| trip_crit | output | 1 | Critical trip flag |
| trip_high | output | 1 | High trip flag |
| trip_low | output | 1 | Low trip flag |
| evt_status | output | 1 | Polarity-independent event state |
| evt_pull_low | output | 1 | Enable for the open-drain pin driver |

## Verification
The assertions assume that reset is held for at least one clock edge before any stimulus. They also assume that strobes and addresses are stable around the rising edge, so that a configuration value seen in one cycle is the one the next update uses. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It lets several cycles pass after each sample or write, so that flags, latch and event settle through their two register stages before the next change. Read addresses run freely over all eight values, including the unused ones.

// File: rtl/temp_evt_pkg.sv
// Shared types and constants for the temperature event controller.
// Assumes a 16-bit register word and addresses fitting in three bits.
package temp_evt_pkg;

    localparam int ADDR_CFG  = 1;
    localparam int ADDR_HIGH = 2;
    localparam int ADDR_LOW  = 3;
    localparam int ADDR_CRIT = 4;
    localparam int ADDR_DATA = 5;

    typedef struct packed {
        logic [1:0] hyst;
        logic       sd;
        logic       lock_crit;
        logic       lock_alarm;
        logic       en;
        logic       crit_only;
        logic       pol;
        logic       mode;
    } evt_cfg_t;

    typedef struct packed {
        logic crit;
        logic high;
        logic low;
    } trip_t;

    // Hysteresis in temperature LSBs: zero, then base doubled per code step.
    function automatic int hyst_ticks(input logic [1:0] code, input int base);
        int amt;
        amt = 0;
        for (int k = 1; k <= 3; k++) begin
            if (code == 2'(k)) amt = base << (k - 1);
        end
        return amt;
    endfunction

endpackage

// File: rtl/temp_evt_cfg.sv
// Configuration register with set-only locks and a clear request pulse.
// Assumes the write strobe is one cycle wide; bit 5 is not stored.
module temp_evt_cfg
    import temp_evt_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output evt_cfg_t      cfg_q,
    output logic          clr_req
);

    evt_cfg_t cfg_d;
    logic     wr_hit;
    logic     locked;

    assign wr_hit  = wr_en && (wr_addr == AW'(ADDR_CFG));
    assign locked  = cfg_q.lock_crit | cfg_q.lock_alarm;
    // Clear request only counts in interrupt mode.
    assign clr_req = wr_hit && wr_data[5] && cfg_q.mode;

    // Next configuration value under the lock rules.
    always_comb begin : cfg_next_calc
        cfg_d = cfg_q;
        if (wr_hit) begin
            cfg_d.lock_crit  = cfg_q.lock_crit  | wr_data[7];
            cfg_d.lock_alarm = cfg_q.lock_alarm | wr_data[6];
            cfg_d.sd         = locked ? (cfg_q.sd & wr_data[8]) : wr_data[8];
            cfg_d.crit_only  = cfg_q.lock_alarm ? (cfg_q.crit_only & wr_data[2]) : wr_data[2];
            if (!locked) begin
                cfg_d.mode = wr_data[0];
                cfg_d.pol  = wr_data[1];
                cfg_d.en   = wr_data[3];
                cfg_d.hyst = wr_data[10:9];
            end
        end
    end

    // Configuration state register.
    always_ff @(posedge clk) begin : cfg_reg
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

endmodule

// File: rtl/temp_evt_limit.sv
// One trip-point register; keeps bits KEEP_HI..KEEP_LO, ignores writes under lock.
// Assumes the lock input is the matching lock bit of the configuration.
module temp_evt_limit #(
    parameter int AW      = 3,
    parameter int DW      = 16,
    parameter int KEEP_HI = 12,
    parameter int KEEP_LO = 2,
    parameter int ADDR    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          lock,
    output logic [DW-1:0] lim_q
);

    localparam logic [DW-1:0] KEEP_MASK =
        DW'(((64'd1 << (KEEP_HI - KEEP_LO + 1)) - 64'd1) << KEEP_LO);

    // Limit storage with field mask.
    always_ff @(posedge clk) begin : lim_reg
        if (!rst_n)
            lim_q <= '0;
        else if (wr_en && wr_addr == AW'(ADDR) && !lock)
            lim_q <= wr_data & KEEP_MASK;
    end

endmodule

// File: rtl/temp_evt_trip.sv
// Temperature store and hysteretic trip flags.
// Assumes limits arrive already aligned to the temperature LSB.
module temp_evt_trip
    import temp_evt_pkg::*;
#(
    parameter int TW        = 13,
    parameter int HYST_BASE = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_valid,
    input  logic [TW-1:0] samp_data,
    input  logic          freeze,
    input  logic [1:0]    hyst_code,
    input  logic [TW-1:0] lim_high,
    input  logic [TW-1:0] lim_low,
    input  logic [TW-1:0] lim_crit,
    output logic [TW-1:0] temp_q,
    output trip_t         trip_q,
    output trip_t         trip_d
);

    localparam int CW = TW + 2;

    logic signed [CW-1:0] t_s, hi_s, lo_s, cr_s, hy_s;

    // Sign-extend operands so limit minus hysteresis cannot wrap.
    always_comb begin : widen_operands
        t_s  = CW'($signed(temp_q));
        hi_s = CW'($signed(lim_high));
        lo_s = CW'($signed(lim_low));
        cr_s = CW'($signed(lim_crit));
        hy_s = CW'(hyst_ticks(hyst_code, HYST_BASE));
    end

    // Next flag values; hysteresis lowers the release point of high and critical.
    always_comb begin : flag_next_calc
        trip_d.crit = trip_q.crit ? (t_s >= cr_s - hy_s) : (t_s >= cr_s);
        trip_d.high = trip_q.high ? (t_s > hi_s - hy_s) : (t_s > hi_s);
        trip_d.low  = (t_s < lo_s);
    end

    // Temperature capture, frozen during shutdown.
    always_ff @(posedge clk) begin : temp_reg
        if (!rst_n)                    temp_q <= '0;
        else if (samp_valid && !freeze) temp_q <= samp_data;
    end

    // Trip flag state.
    always_ff @(posedge clk) begin : flag_reg
        if (!rst_n) trip_q <= '0;
        else        trip_q <= trip_d;
    end

endmodule

// File: rtl/temp_evt_out.sv
// Event latch, deferred clear, event state and pin drive.
// Assumes clr_req is a one-cycle pulse already qualified by interrupt mode.
module temp_evt_out
    import temp_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_cfg_t cfg,
    input  trip_t    trip_q,
    input  trip_t    trip_d,
    input  logic     clr_req,
    output logic     evt_q,
    output logic     pull_low
);

    logic latch_q, pend_q;
    logic win_change, clr_go, cond_now, evt_d;

    // Window crossing detect and clear gating.
    always_comb begin : latch_ctrl
        win_change = ((trip_d.high ^ trip_q.high) | (trip_d.low ^ trip_q.low))
                     & cfg.mode & ~cfg.crit_only;
        clr_go     = pend_q & ~trip_q.crit;
        if (cfg.mode)
            cond_now = latch_q | trip_q.crit;
        else if (cfg.crit_only)
            cond_now = trip_q.crit;
        else
            cond_now = trip_q.crit | trip_q.high | trip_q.low;
        evt_d = cfg.sd ? evt_q : (cfg.en & cond_now);
    end

    // Latch, pending clear and event state registers.
    always_ff @(posedge clk) begin : evt_regs
        if (!rst_n) begin
            latch_q <= 1'b0;
            pend_q  <= 1'b0;
            evt_q   <= 1'b0;
        end else begin
            latch_q <= (latch_q & ~clr_go) | win_change;
            pend_q  <= clr_req | (pend_q & ~clr_go);
            evt_q   <= evt_d;
        end
    end

    // Open-drain enable follows polarity.
    assign pull_low = cfg.pol ? ~evt_q : evt_q;

endmodule

// File: rtl/temp_evt_ctrl.sv
// Top of the temperature event controller: registers, trip flags, event pin.
// Assumes a write and a read port from a bus front end; reads are combinational.
module temp_evt_ctrl
    import temp_evt_pkg::*;
#(
    parameter int TW = 13,
    parameter int DW = 16,
    parameter int AW = 3,
    parameter int HYST_BASE = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_valid,
    input  logic [TW-1:0] samp_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          trip_crit,
    output logic          trip_high,
    output logic          trip_low,
    output logic          evt_status,
    output logic          evt_pull_low
);

    localparam int N_LIM = 3;

    evt_cfg_t      cfg_q;
    logic          clr_req;
    logic [DW-1:0] lim_q [N_LIM];
    logic [TW-1:0] temp_q;
    trip_t         trip_q, trip_d;
    logic          evt_q;

    temp_evt_cfg #(.AW(AW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_q(cfg_q), .clr_req(clr_req)
    );

    // High, low, critical in address order; the last one has its own lock.
    for (genvar gi = 0; gi < N_LIM; gi++) begin : g_lim
        temp_evt_limit #(
            .AW(AW), .DW(DW), .KEEP_HI(TW - 1), .KEEP_LO(2), .ADDR(ADDR_HIGH + gi)
        ) u_lim (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
            .wr_data(wr_data),
            .lock((gi == N_LIM - 1) ? cfg_q.lock_crit : cfg_q.lock_alarm),
            .lim_q(lim_q[gi])
        );
    end

    temp_evt_trip #(.TW(TW), .HYST_BASE(HYST_BASE)) u_trip (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
        .freeze(cfg_q.sd), .hyst_code(cfg_q.hyst),
        .lim_high(lim_q[0][TW-1:0]), .lim_low(lim_q[1][TW-1:0]),
        .lim_crit(lim_q[2][TW-1:0]),
        .temp_q(temp_q), .trip_q(trip_q), .trip_d(trip_d)
    );

    temp_evt_out u_out (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .trip_q(trip_q), .trip_d(trip_d),
        .clr_req(clr_req), .evt_q(evt_q), .pull_low(evt_pull_low)
    );

    // Read multiplexer.
    always_comb begin : rd_mux
        rd_data = '0;
        if (rd_addr == AW'(ADDR_CFG))
            rd_data = DW'({cfg_q.hyst, cfg_q.sd, cfg_q.lock_crit, cfg_q.lock_alarm,
                           1'b0, evt_q, cfg_q.en, cfg_q.crit_only, cfg_q.pol, cfg_q.mode});
        else if (rd_addr == AW'(ADDR_HIGH)) rd_data = lim_q[0];
        else if (rd_addr == AW'(ADDR_LOW))  rd_data = lim_q[1];
        else if (rd_addr == AW'(ADDR_CRIT)) rd_data = lim_q[2];
        else if (rd_addr == AW'(ADDR_DATA))
            rd_data = DW'({trip_q.crit, trip_q.high, trip_q.low, temp_q});
    end

    assign trip_crit  = trip_q.crit;
    assign trip_high  = trip_q.high;
    assign trip_low   = trip_q.low;
    assign evt_status = evt_q;

endmodule

// File: rtl/temp_evt_ctrl_chk.sv
// Property checker for temp_evt_ctrl, attached by bind.
// Assumes synchronous active-low reset is applied before stimulus.
module temp_evt_ctrl_chk #(
    parameter int TW = 13,
    parameter int DW = 16,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          c_mode,
    input logic          c_pol,
    input logic          c_en,
    input logic          c_sd,
    input logic          c_lka,
    input logic          c_lkc,
    input logic [1:0]    c_hyst,
    input logic          evt_status,
    input logic          trip_crit,
    input logic [TW-1:0] temp_q,
    input logic [DW-1:0] crit_lim,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data
);

    assert_temp_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        c_sd |=> $stable(temp_q));

    assert_event_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_sd |=> $stable(evt_status));

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_en && !c_sd) |=> !evt_status);

    assert_crit_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_en && !c_sd && trip_crit) |=> evt_status);

    assert_locks_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_lka || c_lkc) |=> (c_lka || c_lkc));

    assert_lock_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_lka || c_lkc) |=> ($stable(c_mode) && $stable(c_pol) && $stable(c_en) && $stable(c_hyst)));

    assert_no_shutdown_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_lka || c_lkc) && !c_sd) |=> !c_sd);

    assert_crit_limit_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        c_lkc |=> $stable(crit_lim));

    assert_clear_bit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == AW'(1)) |-> !rd_data[5]);

endmodule

bind temp_evt_ctrl temp_evt_ctrl_chk #(.TW(TW), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .c_mode(cfg_q.mode), .c_pol(cfg_q.pol), .c_en(cfg_q.en), .c_sd(cfg_q.sd),
    .c_lka(cfg_q.lock_alarm), .c_lkc(cfg_q.lock_crit), .c_hyst(cfg_q.hyst),
    .evt_status(evt_status), .trip_crit(trip_crit), .temp_q(temp_q),
    .crit_lim(lim_q[2]), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/temp_evt_ctrl_test.sv
// Bench: behavioural reference model compared with the design every clock.
module temp_evt_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_valid = 1'b0;
    logic [12:0] samp_data = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        trip_crit, trip_high, trip_low, evt_status, evt_pull_low;

    int tests = 0;
    int fails = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    temp_evt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .trip_crit(trip_crit), .trip_high(trip_high),
        .trip_low(trip_low), .evt_status(evt_status), .evt_pull_low(evt_pull_low)
    );

    always #2 clk = ~clk;

    // Reference model state.
    bit m_mode, m_pol, m_co, m_en, m_sd, m_lka, m_lkc;
    int m_hy;
    logic [15:0] m_hi, m_lo, m_cr;
    logic [12:0] m_temp;
    bit m_fc, m_fh, m_fl, m_latch, m_pend, m_evt;

    function automatic int sx(input logic [15:0] v);
        return (v[12]) ? int'(v[12:0]) - 8192 : int'(v[12:0]);
    endfunction

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd1: return {5'b0, 2'(m_hy), m_sd, m_lkc, m_lka, 1'b0, m_evt, m_en, m_co, m_pol, m_mode};
            3'd2: return m_hi;
            3'd3: return m_lo;
            3'd4: return m_cr;
            3'd5: return {m_fc, m_fh, m_fl, m_temp};
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int t, h;
        bit nfc, nfh, nfl, setl, go, nlatch, npend, nevt, cond, lk;
        if (!rst_n) begin
            m_mode = 0; m_pol = 0; m_co = 0; m_en = 0; m_sd = 0; m_lka = 0; m_lkc = 0;
            m_hy = 0; m_hi = 0; m_lo = 0; m_cr = 0; m_temp = 0;
            m_fc = 0; m_fh = 0; m_fl = 0; m_latch = 0; m_pend = 0; m_evt = 0;
        end else begin
            t = sx({3'b0, m_temp});
            h = (m_hy == 0) ? 0 : (m_hy == 1) ? 24 : (m_hy == 2) ? 48 : 96;
            nfc = m_fc ? (t >= sx(m_cr) - h) : (t >= sx(m_cr));
            nfh = m_fh ? (t > sx(m_hi) - h) : (t > sx(m_hi));
            nfl = (t < sx(m_lo));
            setl = m_mode && !m_co && ((nfh != m_fh) || (nfl != m_fl));
            go = m_pend && !m_fc;
            nlatch = (go ? 1'b0 : m_latch) | setl;
            npend = go ? 1'b0 : m_pend;
            if (m_mode) cond = m_latch | m_fc;
            else if (m_co) cond = m_fc;
            else cond = m_fc | m_fh | m_fl;
            nevt = m_sd ? m_evt : (m_en && cond);
            if (samp_valid && !m_sd) m_temp = samp_data;
            if (wr_en) begin
                lk = m_lka || m_lkc;
                case (wr_addr)
                    3'd1: begin
                        if (wr_data[5] && m_mode) npend = 1;
                        m_sd = lk ? (m_sd && wr_data[8]) : wr_data[8];
                        m_co = m_lka ? (m_co && wr_data[2]) : wr_data[2];
                        if (!lk) begin
                            m_mode = wr_data[0]; m_pol = wr_data[1];
                            m_en = wr_data[3]; m_hy = int'(wr_data[10:9]);
                        end
                        m_lkc = m_lkc || wr_data[7];
                        m_lka = m_lka || wr_data[6];
                    end
                    3'd2: if (!m_lka) m_hi = wr_data & 16'h1FFC;
                    3'd3: if (!m_lka) m_lo = wr_data & 16'h1FFC;
                    3'd4: if (!m_lkc) m_cr = wr_data & 16'h1FFC;
                    default: ;
                endcase
            end
            m_fc = nfc; m_fh = nfh; m_fl = nfl;
            m_latch = nlatch; m_pend = npend; m_evt = nevt;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, 1 ns after the rising edge.
    always @(posedge clk) begin
        #1;
        if (chk_on) begin
            check("R3/R4 flags", {13'b0, trip_crit, trip_high, trip_low}, {13'b0, m_fc, m_fh, m_fl});
            check("R5/R6/R7/R10/R13 event", {15'b0, evt_status}, {15'b0, m_evt});
            check("R11 pin", {15'b0, evt_pull_low}, {15'b0, m_pol ? !m_evt : m_evt});
            case (rd_addr)
                3'd1: check("R8/R6/R10 config read", rd_data, m_read(rd_addr));
                3'd2, 3'd3, 3'd4: check("R2/R9 limit read", rd_data, m_read(rd_addr));
                3'd5: check("R1 data read", rd_data, m_read(rd_addr));
                default: check("R1 unused address", rd_data, 16'h0000);
            endcase
        end
    end

    always @(negedge clk) rd_addr <= rd_addr + 3'd1;

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic samp(input logic [12:0] v);
        samp_valid = 1; samp_data = v;
        @(negedge clk);
        samp_valid = 0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state, event off, pin released, config zero.
        check("R12 event after reset", {15'b0, evt_status}, 16'h0000);
        check("R12 pin after reset", {15'b0, evt_pull_low}, 16'h0000);
        chk_on = 1;
        // R2: masked limit writes (high 80C, low 20C, crit 96C).
        wr(3'd2, 16'hE503);
        wr(3'd3, 16'h0140);
        wr(3'd4, 16'h0600);
        // R5: comparator mode, enabled.
        wr(3'd1, 16'h0008);
        samp(13'h0320); samp(13'h0510); samp(13'h0100); samp(13'h0610);
        samp(13'h1F00); samp(13'h0320);
        // R4: hysteresis codes 01 and 11.
        wr(3'd1, 16'h0208);
        samp(13'h0510); samp(13'h04F0); samp(13'h04E0);
        wr(3'd1, 16'h0608);
        samp(13'h0610); samp(13'h05C0); samp(13'h0590); samp(13'h0320);
        // R5: critical-only.
        wr(3'd1, 16'h000C);
        samp(13'h0510); samp(13'h0610); samp(13'h0320);
        // R6: interrupt mode latch and clear.
        wr(3'd1, 16'h0009);
        samp(13'h0510); samp(13'h0320);
        wr(3'd1, 16'h0029);
        samp(13'h0100);
        wr(3'd1, 16'h0029);
        // R7: clear held while critical.
        samp(13'h0610);
        wr(3'd1, 16'h0029);
        samp(13'h0620);
        samp(13'h0320);
        // R13: limit write alone raises event (comparator).
        wr(3'd1, 16'h0008);
        wr(3'd2, 16'h0300);
        wr(3'd2, 16'h0500);
        // R11: active-high polarity, enabled and disabled.
        wr(3'd1, 16'h000A);
        samp(13'h0510);
        wr(3'd1, 16'h0002);
        // R10: shutdown freezes temperature and event.
        wr(3'd1, 16'h0008);
        samp(13'h0510);
        wr(3'd1, 16'h0108);
        samp(13'h0320);
        wr(3'd2, 16'h0700);
        wr(3'd1, 16'h0008);
        wr(3'd2, 16'h0500);
        samp(13'h0320);
        // R8/R9: locks are sticky and guard fields and limits.
        wr(3'd1, 16'h0108);
        wr(3'd1, 16'h01C8);
        wr(3'd1, 16'h00CC);
        wr(3'd1, 16'h0703);
        wr(3'd1, 16'h0000);
        wr(3'd4, 16'h0200);
        wr(3'd2, 16'h0100);
        samp(13'h0610);
        samp(13'h0320);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule